// File: doc/BRIEF.md
# Domain and Access Permission Checker

This combinational block rules on a memory access whose address has already been translated. It receives the access address and the attributes of the translation entry that matched: the mapping kind, the domain number and the permission field. It also receives the requester's mode (user or privileged), whether the access is a read, two protection control bits, and the register that holds a two-bit access code for each domain. It returns a grant or fault decision. With a fault it also returns a four-bit status code and the faulting address, which the surrounding logic can capture.

The check runs in two stages. The first stage takes the matched entry's domain code. This code either raises a domain fault, grants the access with no further check (manager), or passes the access on to the permission check (client). In the second stage, the mapping kind and two address bits pick one two-bit permission code from the entry's permission field. That code is then decoded together with the mode, the access direction and the two protection bits.

Top module: `dap_checker`

## Requirements
- R1: The access code of the matched domain `d` is bits [2d+1:2d] of `dom_access_reg`. No other domain's bits affect the decision.
- R2: Access code 2'b00 or 2'b10 gives a fault with status 4'b1001, whatever the permission field and mode are.
- R3: Access code 2'b11 (manager) always grants. `fault` is 0, `fault_code` is 4'b0000 and `fault_addr` is 0.
- R4: Access code 2'b01 (client) runs the permission check. A subpage index is derived from `ent_kind`: 2'b00 section gives index 3, 2'b01 large page gives `acc_addr[15:14]`, 2'b10 small page gives `acc_addr[11:10]`, and 2'b11 tiny page gives index 0. The permission code is `ent_perm[4+2*index +: 2]`.
- R5: Permission code 2'b00 grants only reads, and only when `rom_prot` is 1 or (`sys_prot` is 1 and `acc_is_user` is 0).
- R6: Permission code 2'b01 grants privileged accesses only. Code 2'b10 grants every read, and grants a write only in privileged mode. Code 2'b11 always grants.
- R7: A client denial reports status 4'b1101 for a section and 4'b1111 for any page kind.
- R8: `grant` is always the inverse of `fault`. During a fault, `fault_addr` equals `acc_addr`. During a grant, `fault_addr` is 0 and `fault_code` is 4'b0000.
- R9: Bits of `ent_perm` outside the selected pair, including bits [3:0], have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | 32 | Virtual address of the access |
| acc_is_read | input | 1 | 1 for a read, 0 for a write |
| acc_is_user | input | 1 | 1 when the requester is in user mode |
| sys_prot | input | 1 | System protection control bit |
| rom_prot | input | 1 | ROM protection control bit |
| dom_access_reg | input | 32 | Two-bit access code for each of 16 domains |
| ent_kind | input | 2 | Mapping kind of the matched entry |
| ent_domain | input | 4 | Domain number of the matched entry |
| ent_perm | input | 12 | Permission field of the matched entry |
| grant | output | 1 | Access allowed |
| fault | output | 1 | Access refused |
| fault_code | output | 4 | Fault status code, 0 when granted |
| fault_addr | output | 32 | Faulting address, 0 when granted |

## Verification
Two decisions can bear on the same access: the domain stage and the permission stage. The domain stage must override a permission code that would have granted or refused the access. The bench sweeps all four domain codes against every mapping kind, subpage address, permission pattern, mode and protection setting. Each outcome is judged against a decision model written separately in the bench. The model checks that a domain fault or a manager bypass masks the permission result, and that the reported status belongs to the stage that decided.

// File: rtl/dap_pkg.sv
package dap_pkg;
  typedef enum logic [1:0] {
    PG_SECTION = 2'b00,
    PG_LARGE   = 2'b01,
    PG_SMALL   = 2'b10,
    PG_TINY    = 2'b11
  } pg_kind_e;

  typedef enum logic [1:0] {
    DA_NONE0   = 2'b00,
    DA_CLIENT  = 2'b01,
    DA_NONE2   = 2'b10,
    DA_MANAGER = 2'b11
  } dom_acc_e;

  localparam logic [3:0] FS_NONE     = 4'b0000;
  localparam logic [3:0] FS_DOMAIN   = 4'b1001;
  localparam logic [3:0] FS_SEC_PERM = 4'b1101;
  localparam logic [3:0] FS_SUB_PERM = 4'b1111;

  // Decode of one two-bit permission code for a client domain.
  function automatic logic perm_allows(input logic [1:0] ap, input logic rd,
                                       input logic usr, input logic sp,
                                       input logic rp);
    logic ok;
    case (ap)
      2'b00:   ok = rd & ((sp & ~usr) | rp);
      2'b01:   ok = ~usr;
      2'b10:   ok = rd | ~usr;
      default: ok = 1'b1;
    endcase
    return ok;
  endfunction

  // Subpage slot index for a mapping kind.
  function automatic logic [1:0] slot_of(input pg_kind_e kind,
                                         input logic [1:0] a15_14,
                                         input logic [1:0] a11_10);
    logic [1:0] s;
    case (kind)
      PG_SECTION: s = 2'd3;
      PG_LARGE:   s = a15_14;
      PG_SMALL:   s = a11_10;
      default:    s = 2'd0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dap_domain_sel.sv
module dap_domain_sel #(
  parameter int DOM_W   = 4,
  parameter int NUM_DOM = 1 << DOM_W
) (
  input  logic [2*NUM_DOM-1:0] dreg,
  input  logic [DOM_W-1:0]     dom,
  output logic [1:0]           code
);
  logic [1:0] codes [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign codes[g] = dreg[2*g +: 2];
  end

  assign code = codes[dom];
endmodule

// File: rtl/dap_slot_sel.sv
module dap_slot_sel
  import dap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PERM_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  pg_kind_e          kind,
  input  logic [PERM_W-1:0] perm,
  output logic [1:0]        slot,
  output logic [1:0]        ap
);
  localparam int NSLOT = 4;
  localparam int BASE  = 4;

  logic [1:0] pairs [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_pair
    assign pairs[g] = perm[BASE + 2*g +: 2];
  end

  assign slot = slot_of(kind, addr[15:14], addr[11:10]);
  assign ap   = pairs[slot];
endmodule

// File: rtl/dap_perm_decode.sv
module dap_perm_decode
  import dap_pkg::*;
(
  input  logic [1:0] ap,
  input  logic       rd,
  input  logic       usr,
  input  logic       sp,
  input  logic       rp,
  output logic       ok
);
  assign ok = perm_allows(ap, rd, usr, sp, rp);
endmodule

// File: rtl/dap_checker.sv
module dap_checker
  import dap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DOM_W  = 4,
  parameter int PERM_W = 12
) (
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      acc_is_read,
  input  logic                      acc_is_user,
  input  logic                      sys_prot,
  input  logic                      rom_prot,
  input  logic [2*(1<<DOM_W)-1:0]   dom_access_reg,
  input  logic [1:0]                ent_kind,
  input  logic [DOM_W-1:0]          ent_domain,
  input  logic [PERM_W-1:0]         ent_perm,
  output logic                      grant,
  output logic                      fault,
  output logic [3:0]                fault_code,
  output logic [ADDR_W-1:0]         fault_addr
);
  localparam int NUM_DOM = 1 << DOM_W;

  // Named internal events, visible to the bound checker.
  logic [1:0] dom_code;
  logic [1:0] slot;
  logic [1:0] ap_code;
  logic       perm_ok;
  logic       dom_fault;
  logic       dom_bypass;
  logic       perm_fault;
  pg_kind_e   kind;

  assign kind = pg_kind_e'(ent_kind);

  dap_domain_sel #(.DOM_W(DOM_W), .NUM_DOM(NUM_DOM)) u_dom (
    .dreg (dom_access_reg),
    .dom  (ent_domain),
    .code (dom_code)
  );

  dap_slot_sel #(.ADDR_W(ADDR_W), .PERM_W(PERM_W)) u_slot (
    .addr (acc_addr),
    .kind (kind),
    .perm (ent_perm),
    .slot (slot),
    .ap   (ap_code)
  );

  dap_perm_decode u_dec (
    .ap  (ap_code),
    .rd  (acc_is_read),
    .usr (acc_is_user),
    .sp  (sys_prot),
    .rp  (rom_prot),
    .ok  (perm_ok)
  );

  assign dom_fault  = (dom_code == DA_NONE0) || (dom_code == DA_NONE2);
  assign dom_bypass = (dom_code == DA_MANAGER);
  assign perm_fault = (dom_code == DA_CLIENT) && !perm_ok;

  always_comb begin
    fault_code = FS_NONE;
    if (dom_fault)
      fault_code = FS_DOMAIN;
    else if (perm_fault)
      fault_code = (kind == PG_SECTION) ? FS_SEC_PERM : FS_SUB_PERM;
  end

  assign fault      = dom_fault | perm_fault;
  assign grant      = ~fault;
  assign fault_addr = fault ? acc_addr : '0;
endmodule

// File: rtl/dap_checker_sva.sv
module dap_checker_sva
  import dap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              grant,
  input logic              fault,
  input logic [3:0]        fault_code,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        dom_code,
  input logic [1:0]        ap_code,
  input logic [1:0]        ent_kind
);
  always_comb begin
    a_r8_grant_fault_exclusive: assert (grant != fault);
    if (fault)
      a_r8_fault_addr: assert (fault_addr == acc_addr);
    else
      a_r8_grant_clean: assert (fault_code == FS_NONE && fault_addr == '0);
    if (dom_code[0] == 1'b0)
      a_r2_domain_fault: assert (fault && fault_code == FS_DOMAIN);
    if (dom_code == DA_MANAGER)
      a_r3_manager_grants: assert (grant);
    if (dom_code == DA_CLIENT && ap_code == 2'b11)
      a_r6_open_code_grants: assert (grant);
    if (dom_code == DA_CLIENT && fault)
      a_r7_perm_code: assert (fault_code ==
        ((ent_kind == 2'b00) ? FS_SEC_PERM : FS_SUB_PERM));
  end
endmodule

bind dap_checker dap_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .grant      (grant),
  .fault      (fault),
  .fault_code (fault_code),
  .fault_addr (fault_addr),
  .acc_addr   (acc_addr),
  .dom_code   (dom_code),
  .ap_code    (ap_code),
  .ent_kind   (ent_kind)
);

// File: tb/dap_checker_tb.sv
module dap_checker_tb;
  logic        clk = 1'b0;
  logic [31:0] acc_addr;
  logic        acc_is_read, acc_is_user, sys_prot, rom_prot;
  logic [31:0] dom_access_reg;
  logic [1:0]  ent_kind;
  logic [3:0]  ent_domain;
  logic [11:0] ent_perm;
  logic        grant, fault;
  logic [3:0]  fault_code;
  logic [31:0] fault_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dap_checker u_dut (
    .acc_addr(acc_addr), .acc_is_read(acc_is_read), .acc_is_user(acc_is_user),
    .sys_prot(sys_prot), .rom_prot(rom_prot), .dom_access_reg(dom_access_reg),
    .ent_kind(ent_kind), .ent_domain(ent_domain), .ent_perm(ent_perm),
    .grant(grant), .fault(fault), .fault_code(fault_code), .fault_addr(fault_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model of the permission decode, written as a truth lookup.
  function automatic bit model_ok(int ap, bit rd, bit usr, bit sp, bit rp);
    bit priv = !usr;
    if (ap == 3) return 1;
    if (ap == 2) return rd ? 1 : priv;
    if (ap == 1) return priv;
    if (!rd) return 0;
    return rp || (sp && priv);
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    acc_addr = '0; acc_is_read = 0; acc_is_user = 0; sys_prot = 0; rom_prot = 0;
    dom_access_reg = '0; ent_kind = '0; ent_domain = '0; ent_perm = '0;
    settle();
    // all-zero inputs: domain code 0 gives a domain fault
    chk("R2 idle fault", {31'd0, fault}, 32'd1);
    chk("R2 idle code", {28'd0, fault_code}, 32'h9);

    // R1: only the selected domain's pair counts
    for (int d = 0; d < 16; d++) begin
      for (int t = 0; t < 16; t++) begin
        dom_access_reg = 32'h0;
        dom_access_reg[2*t +: 2] = 2'b11;
        ent_domain = 4'(d);
        acc_addr = 32'h1234_5678 + 32'(d);
        settle();
        chk("R1 domain select", {31'd0, grant}, (d == t) ? 32'd1 : 32'd0);
      end
    end

    // R4/R9: one pair opened, all other bits set to a privileged-only code
    dom_access_reg = {16{2'b01}};
    acc_is_user = 1; acc_is_read = 0; sys_prot = 1; rom_prot = 1;
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 4; a++) begin
        for (int open = 0; open < 4; open++) begin
          int want;
          want = (k == 0) ? 3 : (k == 3) ? 0 : a;
          ent_kind = 2'(k);
          acc_addr = (k == 1) ? (32'(a) << 14) | 32'h0C00 : (32'(a) << 10) | 32'hC000;
          ent_perm = 12'b0101_0101_1111;
          ent_perm[4 + 2*open +: 2] = 2'b11;
          settle();
          chk("R4 slot select", {31'd0, grant}, (open == want) ? 32'd1 : 32'd0);
          chk("R9 other bits ignored", {31'd0, fault}, (open == want) ? 32'd0 : 32'd1);
        end
      end
    end

    // Main sweep: domain code x kind x address x permission x mode x protection
    for (int dc = 0; dc < 4; dc++) begin
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 4; a++) begin
          for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
              int  sl, ap;
              bit  rd, usr, sp, rp, g;
              logic [3:0] code;
              logic [31:0] addr;
              rd = m[0]; usr = m[1]; sp = m[2]; rp = m[3];
              addr = 32'hA000_0000 | (32'(a) << 14) | (32'((a + 1) % 4) << 10) | 32'(p);
              dom_access_reg = {16{2'(dc)}} ^ {16{2'b00}};
              ent_domain = 4'((p * 7 + m) % 16);
              ent_kind = 2'(k);
              ent_perm = 12'(p * 341 + m * 17 + a * 3);
              acc_addr = addr;
              acc_is_read = rd; acc_is_user = usr; sys_prot = sp; rom_prot = rp;
              case (k)
                0: sl = 3;
                1: sl = a;
                2: sl = (a + 1) % 4;
                default: sl = 0;
              endcase
              ap = (int'(ent_perm) >> (4 + 2*sl)) % 4;
              if (dc == 0 || dc == 2) begin g = 0; code = 4'b1001; end
              else if (dc == 3) begin g = 1; code = 4'b0000; end
              else begin
                g = model_ok(ap, rd, usr, sp, rp);
                code = g ? 4'b0000 : (k == 0 ? 4'b1101 : 4'b1111);
              end
              settle();
              if (dc != 1)
                chk(dc == 3 ? "R3 manager grant" : "R2 domain fault",
                    {31'd0, grant}, {31'd0, g});
              else if (ap == 0)
                chk("R5 ap0 decode", {31'd0, grant}, {31'd0, g});
              else
                chk("R6 ap decode", {31'd0, grant}, {31'd0, g});
              chk(dc == 1 ? "R7 status code" : "R2 status code",
                  {28'd0, fault_code}, {28'd0, code});
              chk("R8 fault addr", fault_addr, g ? 32'd0 : addr);
              chk("R8 fault flag", {31'd0, fault}, {31'd0, !g});
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule